// File: doc/BRIEF.md
# Two-Stage Interrupting Watchdog Timer

This block supervises software with a two-stage timeout. Software loads a nonzero timeout into the count register. That write arms the watchdog and starts a main up-counter at zero. When the counter reaches the stored timeout, one of two things happens. If the interrupt-enable bit is clear, the block requests a system reset at once. If the bit is set, the block raises a warning interrupt and starts a second counter, which measures how long software takes to respond. Software answers by writing the clear register. That write drops the interrupt, cancels the reset and restarts the main counter from zero, so supervision goes on. If the second counter reaches the programmed latency limit before any answer, the reset request is issued.

The reset request is a one-cycle pulse. Stretching it and routing it belong to the surrounding reset logic. The pulse also returns the watchdog to its idle state: the stored timeout, both counters and the pending interrupt all go to zero. The latency limit and the enable bit keep their values. The register port is a plain write strobe and a plain read strobe. Read data is registered.

Top module: `irq_watchdog`

## Requirements
- R1: The register map is as follows. Write address 0 is the count register. Address 1 is the latency register. Address 2 is control, where bit 0 is the interrupt enable. Any write to address 3 is a clear. A read strobe returns the result on `rd_data` one cycle later. Read address 0 returns the stored timeout and address 1 the latency value. Address 2 returns the enable in bit 0 and the pending interrupt in bit 1. Address 3 reads as zero.
- R2: A write of a nonzero value T to the count register arms the watchdog, provided T differs from the stored value. With the interrupt enable clear, `sys_rst_req` is then high in the cycle that follows the (T+1)-th rising edge after the write edge.
- R3: With the interrupt enable set, `irq` rises after the (T+1)-th edge after the write edge. If no clear arrives, `sys_rst_req` follows L+1 edges later, where L is the latency value. L = 0 gives a reset one edge after the interrupt.
- R4: A clear write while the interrupt is pending takes effect at its edge. `irq` drops, and no reset follows, even when the latency limit is hit at that same edge. The main counter restarts from zero, so the next interrupt comes T+1 edges after the clear edge.
- R5: A clear write while no interrupt is pending has no effect. In particular, it does not restart the main counter.
- R6: Writing zero to the count register stops the main counter. No interrupt and no reset follow, and the count register reads back zero.
- R7: Writing a nonzero value that differs from the stored one restarts the main counter from zero at that write edge.
- R8: Writing the nonzero value that is already stored leaves a running count undisturbed.
- R9: `sys_rst_req` is high for exactly one cycle. The interrupt is low while it is high. After the pulse, the count register reads zero and nothing further happens until the block is re-armed. The latency value is kept.
- R10: While `rst_n` is low at a rising edge, all registers, counters, `irq`, `sys_rst_req` and `rd_data` go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Registered read data |
| irq | output | 1 | Pending warning interrupt |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
A table of cases combines timeout lengths, latency limits from zero upward, interrupt mode on and off, and software that does or does not answer. For each case the bench times the interrupt edge, the reset edge and the pulse width. These measurements separate the direct-reset path from the interrupt path, and an answered interrupt from an unanswered one. A latency of zero with an answer in the first warning cycle shows which side wins at that shared edge. Directed runs then rewrite the timeout during a count with the same value and with a new value, chosen so that the two outcomes land on different cycles. Further runs stop the count with a zero write, issue a clear with nothing pending, and check the idle state after a reset pulse and after `rst_n`.

// File: rtl/wdt_pkg.sv
// Package: shared register addresses and field positions for the
// two-stage watchdog. Assumes an address bus of at least two bits.
package wdt_pkg;

    // Write/read address of each register
    localparam int ADR_COUNT = 0;
    localparam int ADR_LAT   = 1;
    localparam int ADR_CTRL  = 2;
    localparam int ADR_CLEAR = 3;

    // Bit positions inside the control readback word
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_PEND_BIT = 1;

endpackage

// File: rtl/wdt_upcount.sv
// Module: resettable up-counter with a compare output against a limit.
// The compare is either exact equality or "reached or passed", chosen by
// a parameter. Clear has priority over increment. Assumes the controller
// clears the counter before it can wrap.
module wdt_upcount #(
    parameter int W      = 16,
    parameter bit USE_GE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         hit
);

    // Count register: synchronous reset, then clear, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare variant picked at elaboration
    generate
        if (USE_GE) begin : g_ge
            // Fires once the count has reached or passed the limit
            always_comb hit = (cnt >= limit);
        end else begin : g_eq
            // Fires only on an exact match
            always_comb hit = (cnt == limit);
        end
    endgenerate

endmodule

// File: rtl/wdt_regbank.sv
// Module: register file of the watchdog. It holds the timeout, the
// latency limit and the interrupt enable, decodes the write strobes into
// arm / stop / clear events and drives the registered readback.
// Assumes CNT_W >= 2 so that the control word fits in the read data.
module wdt_regbank
    import wdt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              sys_clear,
    input  logic              pending,
    output logic [CNT_W-1:0]  rd_data,
    output logic [CNT_W-1:0]  timeout_q,
    output logic [CNT_W-1:0]  lat_q,
    output logic              irq_en,
    output logic              arm_wr,
    output logic              stop_wr,
    output logic              clr_wr
);

    logic sel_count;
    logic sel_lat;
    logic sel_ctrl;

    // Write address decode
    always_comb begin
        sel_count = wr_en && (wr_addr == ADDR_W'(ADR_COUNT));
        sel_lat   = wr_en && (wr_addr == ADDR_W'(ADR_LAT));
        sel_ctrl  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
        clr_wr    = wr_en && (wr_addr == ADDR_W'(ADR_CLEAR));
    end

    // Count-register events: a new nonzero value arms, zero stops
    always_comb begin
        arm_wr  = sel_count && (wr_data != '0) && (wr_data != timeout_q);
        stop_wr = sel_count && (wr_data == '0);
    end

    // Timeout register: wiped by the watchdog's own reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_q <= '0;
        end else if (sys_clear) begin
            timeout_q <= '0;
        end else if (sel_count) begin
            timeout_q <= wr_data;
        end
    end

    // Latency limit and enable: kept across the reset pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q  <= '0;
            irq_en <= 1'b0;
        end else begin
            if (sel_lat) begin
                lat_q <= wr_data;
            end
            if (sel_ctrl) begin
                irq_en <= wr_data[CTRL_EN_BIT];
            end
        end
    end

    // Registered readback multiplexer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= '0;
            if (rd_addr == ADDR_W'(ADR_COUNT)) begin
                rd_data <= timeout_q;
            end else if (rd_addr == ADDR_W'(ADR_LAT)) begin
                rd_data <= lat_q;
            end else if (rd_addr == ADDR_W'(ADR_CTRL)) begin
                rd_data[CTRL_EN_BIT]   <= irq_en;
                rd_data[CTRL_PEND_BIT] <= pending;
            end
        end
    end

endmodule

// File: rtl/wdt_ctrl.sv
// Module: sequencer of the two watchdog stages. It steers both counters,
// holds the pending interrupt and issues the one-cycle reset request.
// Priorities at a shared edge: a count-register write beats a main
// timeout, and a clear beats the latency limit.
module wdt_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic irq_en,
    input  logic arm_wr,
    input  logic stop_wr,
    input  logic clr_wr,
    input  logic main_hit,
    input  logic lat_hit,
    output logic main_clr,
    output logic main_inc,
    output logic lat_clr,
    output logic lat_inc,
    output logic pending,
    output logic fire,
    output logic sys_rst_req
);

    logic main_evt;
    logic lat_evt;
    logic clr_ok;
    logic go_warn;

    // Event detection with the write priorities applied
    always_comb begin
        main_evt = armed && !pending && main_hit && !arm_wr && !stop_wr;
        lat_evt  = pending && lat_hit && !clr_wr;
        clr_ok   = pending && clr_wr;
        go_warn  = main_evt && irq_en;
        fire     = (main_evt && !irq_en) || lat_evt;
    end

    // Counter steering: main runs while armed and idle, latency while pending
    always_comb begin
        main_inc = armed && !pending;
        main_clr = arm_wr || stop_wr || main_evt || clr_ok || fire;
        lat_inc  = pending;
        lat_clr  = !pending || clr_ok || lat_evt;
    end

    // Pending interrupt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (fire) begin
            pending <= 1'b0;
        end else if (go_warn) begin
            pending <= 1'b1;
        end else if (clr_ok) begin
            pending <= 1'b0;
        end
    end

    // Reset request pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sys_rst_req <= 1'b0;
        end else begin
            sys_rst_req <= fire;
        end
    end

endmodule

// File: rtl/irq_watchdog.sv
// Module: top of the two-stage interrupting watchdog. It joins the
// register file, the sequencer and the two counters. The main counter
// compares for equality; the latency counter compares "reached or
// passed", so that a lowered limit still ends the warning stage.
module irq_watchdog #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq,
    output logic              sys_rst_req
);

    localparam int NUM_CNT = 2;

    logic [CNT_W-1:0] timeout_q;
    logic [CNT_W-1:0] lat_q;
    logic             irq_en;
    logic             arm_wr;
    logic             stop_wr;
    logic             clr_wr;
    logic             pending;
    logic             fire;
    logic             armed;

    logic [NUM_CNT-1:0]            c_clr;
    logic [NUM_CNT-1:0]            c_inc;
    logic [NUM_CNT-1:0]            c_hit;
    logic [NUM_CNT-1:0][CNT_W-1:0] c_lim;
    logic [NUM_CNT-1:0][CNT_W-1:0] c_val;

    // Armed whenever a nonzero timeout is stored
    always_comb armed = (timeout_q != '0);

    // Limits per counter: index 0 main, index 1 latency
    always_comb begin
        c_lim[0] = timeout_q;
        c_lim[1] = lat_q;
    end

    wdt_regbank #(
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .sys_clear (fire),
        .pending   (pending),
        .rd_data   (rd_data),
        .timeout_q (timeout_q),
        .lat_q     (lat_q),
        .irq_en    (irq_en),
        .arm_wr    (arm_wr),
        .stop_wr   (stop_wr),
        .clr_wr    (clr_wr)
    );

    wdt_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed),
        .irq_en      (irq_en),
        .arm_wr      (arm_wr),
        .stop_wr     (stop_wr),
        .clr_wr      (clr_wr),
        .main_hit    (c_hit[0]),
        .lat_hit     (c_hit[1]),
        .main_clr    (c_clr[0]),
        .main_inc    (c_inc[0]),
        .lat_clr     (c_clr[1]),
        .lat_inc     (c_inc[1]),
        .pending     (pending),
        .fire        (fire),
        .sys_rst_req (sys_rst_req)
    );

    // One counter per stage; the latency stage uses the ">=" compare
    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            wdt_upcount #(
                .W      (CNT_W),
                .USE_GE (i == 1)
            ) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (c_clr[i]),
                .inc   (c_inc[i]),
                .limit (c_lim[i]),
                .cnt   (c_val[i]),
                .hit   (c_hit[i])
            );
        end
    endgenerate

    // Interrupt line follows the pending flag
    always_comb irq = pending;

endmodule

// File: rtl/irq_watchdog_chk.sv
// Module: assertion checker for the watchdog, bound to the top. It only
// observes the ports.
module irq_watchdog_chk #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq,
    input logic              sys_rst_req
);

    logic clear_wr;
    logic zero_wr;

    // Port-level decode of the clear and the stop writes
    always_comb begin
        clear_wr = wr_en && (wr_addr == ADDR_W'(wdt_pkg::ADR_CLEAR));
        zero_wr  = wr_en && (wr_addr == ADDR_W'(wdt_pkg::ADR_COUNT)) && (wr_data == '0);
    end

    // R9
    rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |=> !sys_rst_req);

    // R9
    rst_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> !irq);

    // R4
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && clear_wr) |=> (!irq && !sys_rst_req));

    // R3
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clear_wr) |=> (irq || sys_rst_req));

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && zero_wr) |=> (!irq && !sys_rst_req));

    // R10
    sync_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && !sys_rst_req));

endmodule

bind irq_watchdog irq_watchdog_chk #(
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .irq         (irq),
    .sys_rst_req (sys_rst_req)
);

// File: tb/test_irq_watchdog.sv
`timescale 1ns/1ps
module test_irq_watchdog;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 2;
    localparam int NVEC   = 8;

    typedef struct packed {
        logic [15:0] t;
        logic [15:0] l;
        logic        en;
        logic        clr;
    } vec_t;

    // Timeout, latency, interrupt mode, software answers
    localparam vec_t VECS [NVEC] = '{
        '{16'd5,  16'd3, 1'b1, 1'b0},
        '{16'd5,  16'd3, 1'b0, 1'b0},
        '{16'd1,  16'd0, 1'b1, 1'b0},
        '{16'd8,  16'd2, 1'b1, 1'b1},
        '{16'd3,  16'd6, 1'b1, 1'b1},
        '{16'd2,  16'd0, 1'b0, 1'b0},
        '{16'd4,  16'd0, 1'b1, 1'b1},
        '{16'd12, 16'd1, 1'b1, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [CNT_W-1:0]  wr_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [CNT_W-1:0]  rd_data;
    logic              irq;
    logic              sys_rst_req;

    int tests  = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    irq_watchdog #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_irq_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq), .sys_rst_req(sys_rst_req)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rd_data);
    endtask

    task automatic wait_irq(input int mark, output int n);
        while (!irq && (cyc - mark) < 200) @(negedge clk);
        n = cyc - mark;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int d, mark, n, quiet;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk("R10 irq after reset", int'(irq), 0);
        chk("R10 rst_req after reset", int'(sys_rst_req), 0);
        rd(0, d); chk("R10 count reg after reset", d, 0);
        rd(2, d); chk("R10 ctrl reg after reset", d, 0);
        wr(1, 20); rd(1, d); chk("R1 latency readback", d, 20);

        // Table of timing cases
        for (int v = 0; v < NVEC; v++) begin
            int t, l, win, first_irq, second_irq, first_rst, rst_cyc, rises;
            int exp_irq, exp_rst, exp_second;
            logic prev;
            t = int'(VECS[v].t); l = int'(VECS[v].l);
            wr(1, l); wr(2, int'(VECS[v].en)); wr(0, t);
            first_irq = -1; second_irq = -1; first_rst = -1;
            rst_cyc = 0; rises = 0; prev = 1'b0;
            win = VECS[v].clr ? 2 * t + 4 : t + l + 6;
            for (int k = 0; k <= win; k++) begin
                if (irq && !prev) begin
                    rises++;
                    if (rises == 1) first_irq = k; else second_irq = k;
                end
                if (VECS[v].clr && k == t + 2)
                    chk("R4 irq drops after clear", int'(irq), 0);
                if (sys_rst_req) begin
                    if (first_rst < 0) first_rst = k;
                    rst_cyc++;
                end
                prev = irq;
                if (VECS[v].clr && irq) begin
                    wr_en = 1'b1; wr_addr = 2'd3; wr_data = '0;
                end else begin
                    wr_en = 1'b0;
                end
                @(negedge clk);
            end
            wr_en = 1'b0;
            exp_irq    = VECS[v].en ? t + 1 : -1;
            exp_rst    = !VECS[v].en ? t + 1 : (VECS[v].clr ? -1 : t + 2 + l);
            exp_second = VECS[v].clr ? 2 * t + 3 : -1;
            chk(VECS[v].en ? "R3 irq cycle" : "R2 no irq when disabled", first_irq, exp_irq);
            chk(VECS[v].en ? "R3 reset cycle" : "R2 direct reset cycle", first_rst, exp_rst);
            chk("R9 reset pulse width", rst_cyc, (exp_rst < 0) ? 0 : 1);
            chk("R4 restart after clear", second_irq, exp_second);
            if (VECS[v].clr) begin
                wr(0, 0);
            end else begin
                rd(0, d); chk("R9 count reg zero after pulse", d, 0);
                rd(1, d); chk("R9 latency kept after pulse", d, l);
            end
        end

        // Directed cases use interrupt mode with a long latency
        wr(1, 40); wr(2, 1);

        // R8 same value rewritten at edge 4
        wr(0, 10); mark = cyc;
        repeat (3) @(negedge clk);
        wr(0, 10);
        wait_irq(mark, n); chk("R8 same value no restart", n, 11);
        wr(3, 0); wr(0, 0);

        // R7 new value written at edge 4
        wr(0, 10); mark = cyc;
        repeat (3) @(negedge clk);
        wr(0, 8);
        wait_irq(mark, n); chk("R7 new value restarts", n, 13);
        rd(2, d); chk("R1 ctrl shows pending", d, 3);
        wr(3, 0); wr(0, 0);

        // R5 clear with nothing pending at edge 3
        wr(0, 6); mark = cyc;
        repeat (2) @(negedge clk);
        wr(3, 0);
        wait_irq(mark, n); chk("R5 clear ignored when idle", n, 7);
        wr(3, 0); wr(0, 0);
        rd(2, d); chk("R5 ctrl after clear", d, 1);

        // R6 stop by writing zero
        wr(0, 5); wr(0, 0);
        quiet = 0;
        for (int k = 0; k < 20; k++) begin
            if (irq || sys_rst_req) quiet++;
            @(negedge clk);
        end
        chk("R6 no event after stop", quiet, 0);
        rd(0, d); chk("R6 count reg reads zero", d, 0);

        // R10 reset during a running count
        wr(0, 30);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(0, d); chk("R10 count cleared by rst_n", d, 0);
        rd(1, d); chk("R10 latency cleared by rst_n", d, 0);
        quiet = 0;
        for (int k = 0; k < 40; k++) begin
            if (irq || sys_rst_req) quiet++;
            @(negedge clk);
        end
        chk("R10 idle after rst_n", quiet, 0);

        finish_run();
    end

endmodule